// File: doc/BRIEF.md
# Virtual Address Tag Stripper

This block turns a 64-bit virtual branch target into the value that is written to the program counter. When the active translation regime ignores the top address byte, the tag bits above bit 55 are removed. The stripped address is then sign-extended or zero-extended, depending on the privilege level and on whether the core runs in host mode. For a 32-bit regime only the low 32 bits are kept. Otherwise the address passes through unchanged.

The unit is purely combinational and sits on the branch path. The caller supplies the following inputs:

- the address;
- whether the access is an instruction access;
- the current privilege level;
- flags for a 32-bit regime, for host mode and for pointer authentication being present;
- the tag-ignore enable bits and the instruction-tag-disable bits of each regime.

The block reports two results: the index of the top address bit that stays meaningful, and the stripped address.

Top module: `vaddr_tag_strip`

## Requirements
- R1: `top_idx_o` is always one of 31, 55 or 63.
  - It is 55 when the effective tag-ignore value is 1 and the regime is not 32-bit.
  - It is 63 when that value is 0 and the regime is not 32-bit.
- R2: When `top_idx_o` is 63, `pc_o` equals `addr_i` exactly.
- R3: Sign extension applies when `top_idx_o` is not 63, `addr_i[top_idx_o]` is 1, and either `lvl_i` is 0 or 1 or `host_i` is 1.
  - In that case `pc_o` keeps bits `[top_idx_o:0]` and sets every bit above them to 1.
- R4: In every other case with `top_idx_o` not 63, `pc_o` keeps bits `[top_idx_o:0]` and clears every bit above them.
- R5: The level-1 regime uses the `e1_*` bits. It applies at `lvl_i`=1, and at `lvl_i`=0 when `host_i`=0.
  - The `_hi` variants are taken when `addr_i[55]` is 1.
  - The `_lo` variants are taken when `addr_i[55]` is 0.
- R6: The host regime uses the `e2h_*` bits. It applies at `lvl_i`=2 or `lvl_i`=0 when `host_i`=1.
  - The `_hi` variants are taken when `addr_i[55]` is 1.
  - The `_lo` variants are taken when `addr_i[55]` is 0.
- R7: At `lvl_i`=2 with `host_i`=0, only `e2_tag_i` and `e2_itag_off_i` are used. At `lvl_i`=3, only `e3_tag_i` and `e3_itag_off_i` are used. In both cases `addr_i[55]` has no effect on which bits are chosen.
- R8: The effective tag-ignore value is 1 only when the selected tag bit is 1 and at least one of the following holds:
  - `pauth_i` is 0;
  - the selected instruction-tag-disable bit is 0;
  - `is_instr_i` is 0.
- R9: When `narrow_i` is 1, `top_idx_o` is 31 whatever the configuration bits.
  - The sign or zero fill of R3/R4 then starts at bit 32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| addr_i | input | 64 | Virtual branch target |
| is_instr_i | input | 1 | 1 for an instruction access |
| lvl_i | input | 2 | Current privilege level, 0 to 3 |
| narrow_i | input | 1 | Stage 1 regime is 32-bit |
| host_i | input | 1 | Host mode active |
| pauth_i | input | 1 | Pointer authentication present |
| e1_tag_lo_i | input | 1 | Level-1 tag ignore, low half |
| e1_tag_hi_i | input | 1 | Level-1 tag ignore, high half |
| e1_itag_off_lo_i | input | 1 | Level-1 instruction tag disable, low half |
| e1_itag_off_hi_i | input | 1 | Level-1 instruction tag disable, high half |
| e2h_tag_lo_i | input | 1 | Host regime tag ignore, low half |
| e2h_tag_hi_i | input | 1 | Host regime tag ignore, high half |
| e2h_itag_off_lo_i | input | 1 | Host regime instruction tag disable, low half |
| e2h_itag_off_hi_i | input | 1 | Host regime instruction tag disable, high half |
| e2_tag_i | input | 1 | Level-2 tag ignore |
| e2_itag_off_i | input | 1 | Level-2 instruction tag disable |
| e3_tag_i | input | 1 | Level-3 tag ignore |
| e3_itag_off_i | input | 1 | Level-3 instruction tag disable |
| top_idx_o | output | 6 | Index of the top meaningful address bit |
| pc_o | output | 64 | Stripped address for the program counter |

## Verification
The hardest case to reach is a wrong-half selection, where the block reads the configuration bit for the half that `addr_i[55]` did not pick. Such a bug hides whenever both halves hold the same value.

The stimulus therefore sets the twelve configuration bits from a pseudo-random stream, so that paired bits differ in many vectors. This stream is walked across every combination of the following:

- level;
- host mode;
- 32-bit regime;
- instruction flag;
- pointer authentication;
- `addr_i[55]`.

Directed table rows set the chosen half and the opposite half to opposite values. A wrong pick then flips `top_idx_o` between 55 and 63.

// File: rtl/vts_pkg.sv
package vts_pkg;
    localparam int ADDR_W   = 64;
    localparam int IDX_W    = $clog2(ADDR_W);
    localparam int TAG_BIT  = 55;
    localparam int NARROW_T = 31;
    localparam int FULL_T   = ADDR_W - 1;

    typedef enum logic [1:0] {
        RG_L1   = 2'd0,
        RG_HOST = 2'd1,
        RG_L2   = 2'd2,
        RG_L3   = 2'd3
    } regime_e;

    typedef struct packed {
        logic tag;
        logic itag_off;
    } sel_t;
endpackage

// File: rtl/vts_regime_sel.sv
module vts_regime_sel
    import vts_pkg::*;
(
    input  logic             hi_half_i,
    input  logic [1:0]       lvl_i,
    input  logic             host_i,
    input  logic             narrow_i,
    input  logic             is_instr_i,
    input  logic             pauth_i,
    input  sel_t             l1_lo_i,
    input  sel_t             l1_hi_i,
    input  sel_t             hs_lo_i,
    input  sel_t             hs_hi_i,
    input  sel_t             l2_i,
    input  sel_t             l3_i,
    output logic             eff_tag_o,
    output logic [IDX_W-1:0] top_idx_o
);
    regime_e regime;
    sel_t    pick;

    always_comb begin
        case (lvl_i)
            2'd0:    regime = host_i ? RG_HOST : RG_L1;
            2'd1:    regime = RG_L1;
            2'd2:    regime = host_i ? RG_HOST : RG_L2;
            default: regime = RG_L3;
        endcase
    end

    always_comb begin
        case (regime)
            RG_L1:   pick = hi_half_i ? l1_hi_i : l1_lo_i;
            RG_HOST: pick = hi_half_i ? hs_hi_i : hs_lo_i;
            RG_L2:   pick = l2_i;
            default: pick = l3_i;
        endcase
    end

    always_comb begin
        eff_tag_o = pick.tag & (~pauth_i | ~pick.itag_off | ~is_instr_i);
        if (narrow_i)
            top_idx_o = IDX_W'(NARROW_T);
        else if (eff_tag_o)
            top_idx_o = IDX_W'(TAG_BIT);
        else
            top_idx_o = IDX_W'(FULL_T);
    end

    always_comb begin
        // a_r8_eff_needs_tag: a clear selected tag bit never enables stripping
        a_r8_eff_needs_tag: assert (pick.tag || !eff_tag_o);
    end
endmodule

// File: rtl/vts_extend.sv
module vts_extend
    import vts_pkg::*;
(
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [IDX_W-1:0]  top_idx_i,
    input  logic              sign_ok_i,
    output logic [ADDR_W-1:0] pc_o
);
    logic passthru;
    logic fill;

    assign passthru = (top_idx_i == IDX_W'(FULL_T));
    assign fill     = ~passthru & sign_ok_i & addr_i[top_idx_i];

    for (genvar i = 0; i < ADDR_W; i++) begin : g_bit
        assign pc_o[i] = (IDX_W'(i) <= top_idx_i) ? addr_i[i] : fill;
    end
endmodule

// File: rtl/vaddr_tag_strip.sv
module vaddr_tag_strip
    import vts_pkg::*;
(
    input  logic [63:0] addr_i,
    input  logic        is_instr_i,
    input  logic [1:0]  lvl_i,
    input  logic        narrow_i,
    input  logic        host_i,
    input  logic        pauth_i,
    input  logic        e1_tag_lo_i,
    input  logic        e1_tag_hi_i,
    input  logic        e1_itag_off_lo_i,
    input  logic        e1_itag_off_hi_i,
    input  logic        e2h_tag_lo_i,
    input  logic        e2h_tag_hi_i,
    input  logic        e2h_itag_off_lo_i,
    input  logic        e2h_itag_off_hi_i,
    input  logic        e2_tag_i,
    input  logic        e2_itag_off_i,
    input  logic        e3_tag_i,
    input  logic        e3_itag_off_i,
    output logic [5:0]  top_idx_o,
    output logic [63:0] pc_o
);
    logic             eff_tag;
    logic [IDX_W-1:0] top_idx;
    logic             sign_ok;

    assign sign_ok = (lvl_i == 2'd0) | (lvl_i == 2'd1) | host_i;

    vts_regime_sel u_sel (
        .hi_half_i  (addr_i[TAG_BIT]),
        .lvl_i      (lvl_i),
        .host_i     (host_i),
        .narrow_i   (narrow_i),
        .is_instr_i (is_instr_i),
        .pauth_i    (pauth_i),
        .l1_lo_i    ('{tag: e1_tag_lo_i,  itag_off: e1_itag_off_lo_i}),
        .l1_hi_i    ('{tag: e1_tag_hi_i,  itag_off: e1_itag_off_hi_i}),
        .hs_lo_i    ('{tag: e2h_tag_lo_i, itag_off: e2h_itag_off_lo_i}),
        .hs_hi_i    ('{tag: e2h_tag_hi_i, itag_off: e2h_itag_off_hi_i}),
        .l2_i       ('{tag: e2_tag_i,     itag_off: e2_itag_off_i}),
        .l3_i       ('{tag: e3_tag_i,     itag_off: e3_itag_off_i}),
        .eff_tag_o  (eff_tag),
        .top_idx_o  (top_idx)
    );

    vts_extend u_ext (
        .addr_i    (addr_i),
        .top_idx_i (top_idx),
        .sign_ok_i (sign_ok),
        .pc_o      (pc_o)
    );

    assign top_idx_o = top_idx;

    logic [ADDR_W-1:0] keep_mask;

    always_comb begin
        keep_mask = (ADDR_W'(1) << (top_idx + IDX_W'(1))) - ADDR_W'(1);
        // R1: index confined to the three legal values
        a_r1_top_legal: assert (top_idx == 6'd31 || top_idx == 6'd55 || top_idx == 6'd63);
        // R9: a 32-bit regime always reports 31
        a_r9_narrow: assert (!narrow_i || top_idx == 6'd31);
        // R2: full-width index leaves the address untouched
        a_r2_pass: assert (top_idx != 6'd63 || pc_o == addr_i);
        if (top_idx != 6'd63) begin
            // R3/R4: low bits are kept
            a_r4_low_kept: assert ((pc_o & keep_mask) == (addr_i & keep_mask));
            // R3: sign fill only where allowed
            a_r3_sign_fill: assert ((pc_o & ~keep_mask) ==
                ((sign_ok && addr_i[top_idx]) ? ~keep_mask : '0));
        end
    end
endmodule

// File: tb/vaddr_tag_strip_test.sv
module vaddr_tag_strip_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic [63:0] addr;
    logic        is_instr, narrow, host, pauth;
    logic [1:0]  lvl;
    logic [11:0] cfg;
    logic [5:0]  top_idx;
    logic [63:0] pc;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // cfg bit order: 0 e1_tag_lo,1 e1_tag_hi,2 e1_off_lo,3 e1_off_hi,
    // 4 e2h_tag_lo,5 e2h_tag_hi,6 e2h_off_lo,7 e2h_off_hi,
    // 8 e2_tag,9 e2_off,10 e3_tag,11 e3_off
    vaddr_tag_strip uut (
        .addr_i(addr), .is_instr_i(is_instr), .lvl_i(lvl), .narrow_i(narrow),
        .host_i(host), .pauth_i(pauth),
        .e1_tag_lo_i(cfg[0]), .e1_tag_hi_i(cfg[1]),
        .e1_itag_off_lo_i(cfg[2]), .e1_itag_off_hi_i(cfg[3]),
        .e2h_tag_lo_i(cfg[4]), .e2h_tag_hi_i(cfg[5]),
        .e2h_itag_off_lo_i(cfg[6]), .e2h_itag_off_hi_i(cfg[7]),
        .e2_tag_i(cfg[8]), .e2_itag_off_i(cfg[9]),
        .e3_tag_i(cfg[10]), .e3_itag_off_i(cfg[11]),
        .top_idx_o(top_idx), .pc_o(pc)
    );

    function automatic void ref_model(input logic [63:0] a, input logic [1:0] l,
        input logic h, input logic n, input logic ins, input logic pa,
        input logic [11:0] c, output logic [5:0] t, output logic [63:0] p);
        logic tg, off, hi, eff, sgn;
        hi = a[55];
        if ((l == 2'd0 && !h) || l == 2'd1) begin          // R5
            tg = hi ? c[1] : c[0]; off = hi ? c[3] : c[2];
        end else if (l == 2'd0 || (l == 2'd2 && h)) begin  // R6
            tg = hi ? c[5] : c[4]; off = hi ? c[7] : c[6];
        end else if (l == 2'd2) begin                      // R7
            tg = c[8]; off = c[9];
        end else begin
            tg = c[10]; off = c[11];
        end
        eff = tg && (!pa || !off || !ins);                 // R8
        t = n ? 6'd31 : (eff ? 6'd55 : 6'd63);             // R1, R9
        if (t == 6'd63) p = a;                             // R2
        else begin
            sgn = (l <= 2'd1 || h) && a[t];
            p = a;
            for (int i = 0; i < 64; i++)
                if (i > int'(t)) p[i] = sgn;               // R3, R4
        end
    endfunction

    task automatic check(input string req, input logic [5:0] et, input logic [63:0] ep);
        checks++;
        if (top_idx !== et || pc !== ep) begin
            errors++;
            $display("FAIL %s: top=%0d pc=%h expected top=%0d pc=%h",
                     req, top_idx, pc, et, ep);
        end
    endtask

    typedef struct packed {
        logic [3:0]  req;
        logic [1:0]  el;
        logic        host;
        logic        narrow;
        logic        instr;
        logic        pac;
        logic [11:0] cfg;
        logic [63:0] addr;
        logic [5:0]  top;
        logic [63:0] pc;
    } vec_t;

    localparam vec_t VEC [10] = '{
        '{4'd5, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 12'h002, 64'h00FF_0000_1234_5678, 6'd55, 64'hFFFF_0000_1234_5678}, // R5
        '{4'd5, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 12'h001, 64'h00FF_0000_1234_5678, 6'd63, 64'h00FF_0000_1234_5678}, // R5
        '{4'd6, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 12'h010, 64'hAB7F_0000_0000_0010, 6'd55, 64'h007F_0000_0000_0010}, // R6
        '{4'd6, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 12'h001, 64'hAB7F_0000_0000_0010, 6'd63, 64'hAB7F_0000_0000_0010}, // R6
        '{4'd7, 2'd2, 1'b0, 1'b0, 1'b0, 1'b0, 12'h100, 64'h12FF_8000_0000_0000, 6'd55, 64'h00FF_8000_0000_0000}, // R7
        '{4'd7, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 12'h400, 64'h3400_0000_0000_0001, 6'd55, 64'h0000_0000_0000_0001}, // R7
        '{4'd8, 2'd1, 1'b0, 1'b0, 1'b1, 1'b1, 12'h005, 64'h5500_0000_0000_0040, 6'd63, 64'h5500_0000_0000_0040}, // R8
        '{4'd8, 2'd1, 1'b0, 1'b0, 1'b0, 1'b1, 12'h005, 64'h5500_0000_0000_0040, 6'd55, 64'h0000_0000_0000_0040}, // R8
        '{4'd9, 2'd1, 1'b0, 1'b1, 1'b0, 1'b0, 12'hFFF, 64'hDEAD_BEEF_8000_0004, 6'd31, 64'hFFFF_FFFF_8000_0004}, // R9
        '{4'd9, 2'd2, 1'b0, 1'b1, 1'b0, 1'b0, 12'hFFF, 64'hDEAD_BEEF_8000_0004, 6'd31, 64'h0000_0000_8000_0004}  // R9
    };

    initial begin
        logic [63:0] seed;
        logic [5:0]  et;
        logic [63:0] ep;
        addr = '0; is_instr = 0; lvl = 0; narrow = 0; host = 0; pauth = 0; cfg = '0;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R2 idle", 6'd63, 64'd0);

        for (int v = 0; v < 10; v++) begin
            @(posedge clk);
            lvl = VEC[v].el; host = VEC[v].host; narrow = VEC[v].narrow;
            is_instr = VEC[v].instr; pauth = VEC[v].pac; cfg = VEC[v].cfg; addr = VEC[v].addr;
            @(negedge clk);
            check($sformatf("R%0d table row %0d", VEC[v].req, v), VEC[v].top, VEC[v].pc);
        end

        seed = 64'h1234_5678_9ABC_DEF0;
        for (int l = 0; l < 4; l++)
        for (int h = 0; h < 2; h++)
        for (int n = 0; n < 2; n++)
        for (int ins = 0; ins < 2; ins++)
        for (int pa = 0; pa < 2; pa++)
        for (int b = 0; b < 2; b++)
        for (int k = 0; k < 16; k++) begin
            @(posedge clk);
            seed = seed * 64'd6364136223846793005 + 64'd1442695040888963407;
            lvl = 2'(l); host = h[0]; narrow = n[0]; is_instr = ins[0]; pauth = pa[0];
            cfg = seed[52:41];
            addr = seed ^ {seed[31:0], seed[63:32]};
            addr[55] = b[0];
            @(negedge clk);
            ref_model(addr, lvl, host, narrow, is_instr, pauth, cfg, et, ep);
            if (et == 6'd63)
                check("R1/R2/R5/R6/R7/R8 sweep", et, ep);
            else
                check("R1/R3/R4/R9 sweep", et, ep);
        end
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #1000000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule